// File: doc/BRIEF.md
# Ping-Pong Card Data Buffer

This block sits between a host register port and the word stream of a memory-card data path. It stores whole data blocks in a local memory. The host writes and reads through one 32-bit data register. A host write lands in a post-write register and is then committed to memory. A host read returns a prefetch register that the buffer has already loaded from memory. The card side is a plain valid/ready word stream in each direction. A direction input selects which side fills the memory and which side drains it, and it is held stable between resets.

The block length in bytes is programmable. It sets the number of 32-bit words per block. When a block fits in half the memory, the two halves act as alternating banks. The producer can then fill one bank while the consumer empties the other. A longer block uses the whole memory as one bank, so filling and draining take turns. Two status flags tell the host when a read or a write is allowed. A sticky flag records any host access made while the matching flag was low.

Top module: `sdbuf_top`

## Requirements
- R1: A synchronous reset empties both banks and clears `bad_acc`. After reset in host-read direction (`dir_to_host`=1), `rd_avail`=0, `card_out_valid`=0 and `card_in_ready`=1. In host-write direction, `wr_room`=1.
- R2: Words per block = ceil(`blk_len`/4). A length of 0 counts as 1 word, and the count is capped at MEM_WORDS (256 by default).
- R3: When the word count is at most MEM_WORDS/2, two banks alternate. The producer side keeps accepting the next block while the previous block is still being drained, and it stalls only when both banks hold complete blocks.
- R4: When the word count exceeds MEM_WORDS/2, a single bank is used. After a block completes, `card_in_ready` stays 0 until that block has been moved out of memory.
- R5: In host-read direction, host reads return the card words in arrival order. `rd_avail` rises in the second cycle after the last word of a block is accepted, provided the prefetch register was empty.
- R6: `rd_avail` is 0 once the last word of the last complete block has been read.
- R7: In host-write direction, `wr_room` is 0 in the cycle after the last word of a block is accepted. The host words leave on `card_out_data` in order.
- R8: A host read while `rd_avail`=0, or a host write while `wr_room`=0, sets `bad_acc`. Rejected write data never reaches the card side.
- R9: `bad_acc` stays set until a `bad_clr` pulse. A new bad access in the same cycle as `bad_clr` wins.
- R10: `host_rdata` always shows the prefetch register. A host write never changes it.
- R11: `cap_blk_bytes` is the fixed value MEM_WORDS*4 (1024 by default).
- R12: While `card_out_valid` is 1 and `card_out_ready` is 0, the output word is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dir_to_host | input | 1 | 1: card fills, host reads; 0: host writes, card drains |
| blk_len | input | 11 | Block length in bytes |
| cap_blk_bytes | output | 11 | Fixed maximum block size in bytes |
| host_wr | input | 1 | Host write strobe to the data register |
| host_wdata | input | 32 | Host write data |
| host_rd | input | 1 | Host read strobe from the data register |
| host_rdata | output | 32 | Prefetch register contents |
| rd_avail | output | 1 | Host read allowed |
| wr_room | output | 1 | Host write allowed |
| bad_acc | output | 1 | Sticky bad-access flag |
| bad_clr | input | 1 | Clear pulse for bad_acc |
| card_in_valid | input | 1 | Card word valid (host-read direction) |
| card_in_data | input | 32 | Card word |
| card_in_ready | output | 1 | Buffer accepts a card word |
| card_out_valid | output | 1 | Word for the card valid (host-write direction) |
| card_out_data | output | 32 | Word for the card |
| card_out_ready | input | 1 | Card takes the word |

## Verification
Some properties are checked on every cycle: that illegal host accesses set the flag, that the flag stays set until cleared, that the outgoing card word holds under backpressure, and that reset leaves status clear. The bench scenarios are needed for the rest, because these depend on whole sequences. They cover word ordering through both banks, the exact cycle in which the status flags move, the different stall behaviour of single-bank and dual-bank lengths, the rounding and capping of the block length, and the discarding of rejected write data.

// File: rtl/sdbuf_pkg.sv
package sdbuf_pkg;
    localparam int unsigned WORD_W = 32;
    typedef enum logic {
        DIR_TO_CARD = 1'b0,
        DIR_TO_HOST = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/sdbuf_geom.sv
// Converts the byte length into the last word index of a block and picks bank mode.
module sdbuf_geom #(
    parameter int unsigned BLEN_W    = 11,
    parameter int unsigned MEM_WORDS = 256,
    parameter int unsigned CW        = $clog2(MEM_WORDS)
) (
    input  logic [BLEN_W-1:0] blk_len,
    output logic [CW-1:0]     last_idx,
    output logic              dual
);
    localparam logic [BLEN_W:0] MEMW_L = (BLEN_W+1)'(MEM_WORDS);
    localparam logic [BLEN_W:0] HALF_L = (BLEN_W+1)'(MEM_WORDS / 2);

    logic [BLEN_W:0] ceil_w;
    logic [BLEN_W:0] words;

    always_comb begin
        ceil_w = ({1'b0, blk_len} + (BLEN_W+1)'(3)) >> 2;
        if (ceil_w == '0) begin
            words = (BLEN_W+1)'(1);
        end else if (ceil_w > MEMW_L) begin
            words = MEMW_L;
        end else begin
            words = ceil_w;
        end
        last_idx = CW'(words - (BLEN_W+1)'(1));
        dual     = (words <= HALF_L);
    end
endmodule

// File: rtl/sdbuf_ram.sv
// Single write port, single registered read port.
module sdbuf_ram #(
    parameter int unsigned WORDS = 256,
    parameter int unsigned W     = 32,
    parameter int unsigned AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem_q[raddr];
        end
    end
endmodule

// File: rtl/sdbuf_top.sv
module sdbuf_top
    import sdbuf_pkg::*;
#(
    parameter int unsigned BLEN_W    = 11,
    parameter int unsigned MEM_WORDS = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                dir_to_host,
    input  logic [BLEN_W-1:0]   blk_len,
    output logic [BLEN_W-1:0]   cap_blk_bytes,
    input  logic                host_wr,
    input  logic [WORD_W-1:0]   host_wdata,
    input  logic                host_rd,
    output logic [WORD_W-1:0]   host_rdata,
    output logic                rd_avail,
    output logic                wr_room,
    output logic                bad_acc,
    input  logic                bad_clr,
    input  logic                card_in_valid,
    input  logic [WORD_W-1:0]   card_in_data,
    output logic                card_in_ready,
    output logic                card_out_valid,
    output logic [WORD_W-1:0]   card_out_data,
    input  logic                card_out_ready
);
    localparam int unsigned AW = $clog2(MEM_WORDS);

    typedef struct packed {
        logic [1:0]        full;
        logic              fill_bank;
        logic [AW-1:0]     fill_ptr;
        logic              drain_bank;
        logic [AW-1:0]     drain_ptr;
        logic              ob_valid;
        logic              pw_valid;
        logic [WORD_W-1:0] pw_data;
        logic              bad;
    } st_t;

    st_t st_q, st_d;

    logic [AW-1:0]     last_idx;
    logic              dual;
    logic              to_host;
    logic              fill_full, drain_full;
    logic              fill_fire, fill_last, drain_last;
    logic              consume, load;
    logic              wr_ok, bad_hit;
    logic [AW-1:0]     fill_addr, drain_addr;
    logic [WORD_W-1:0] fill_data;
    logic [WORD_W-1:0] ram_rdata;

    sdbuf_geom #(.BLEN_W(BLEN_W), .MEM_WORDS(MEM_WORDS), .CW(AW)) u_geom (
        .blk_len  (blk_len),
        .last_idx (last_idx),
        .dual     (dual)
    );

    sdbuf_ram #(.WORDS(MEM_WORDS), .W(WORD_W), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (fill_fire),
        .waddr (fill_addr),
        .wdata (fill_data),
        .re    (load),
        .raddr (drain_addr),
        .rdata (ram_rdata)
    );

    always_comb begin
        to_host    = (xfer_dir_e'(dir_to_host) == DIR_TO_HOST);
        fill_full  = st_q.full[st_q.fill_bank];
        drain_full = st_q.full[st_q.drain_bank];
        fill_last  = (st_q.fill_ptr == last_idx);
        drain_last = (st_q.drain_ptr == last_idx);
        fill_addr  = dual ? {st_q.fill_bank, st_q.fill_ptr[AW-2:0]} : st_q.fill_ptr;
        drain_addr = dual ? {st_q.drain_bank, st_q.drain_ptr[AW-2:0]} : st_q.drain_ptr;

        card_in_ready = to_host && !fill_full;
        wr_room       = !to_host && !fill_full && !(st_q.pw_valid && fill_last);
        rd_avail      = to_host && st_q.ob_valid;
        fill_fire     = to_host ? (card_in_valid && !fill_full) : st_q.pw_valid;
        fill_data     = to_host ? card_in_data : st_q.pw_data;
        consume       = st_q.ob_valid && (to_host ? host_rd : card_out_ready);
        load          = drain_full && (!st_q.ob_valid || consume);
        wr_ok         = host_wr && wr_room;
        bad_hit       = (host_wr && !wr_room) || (host_rd && !rd_avail);

        st_d          = st_q;
        st_d.pw_valid = wr_ok;
        if (wr_ok) begin
            st_d.pw_data = host_wdata;
        end

        if (load) begin
            st_d.ob_valid = 1'b1;
            if (drain_last) begin
                st_d.full[st_q.drain_bank] = 1'b0;
                st_d.drain_ptr             = '0;
                st_d.drain_bank            = dual ? ~st_q.drain_bank : 1'b0;
            end else begin
                st_d.drain_ptr = st_q.drain_ptr + AW'(1);
            end
        end else if (consume) begin
            st_d.ob_valid = 1'b0;
        end

        if (fill_fire) begin
            if (fill_last) begin
                st_d.full[st_q.fill_bank] = 1'b1;
                st_d.fill_ptr             = '0;
                st_d.fill_bank            = dual ? ~st_q.fill_bank : 1'b0;
            end else begin
                st_d.fill_ptr = st_q.fill_ptr + AW'(1);
            end
        end

        if (bad_hit) begin
            st_d.bad = 1'b1;
        end else if (bad_clr) begin
            st_d.bad = 1'b0;
        end

        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cap_blk_bytes  = BLEN_W'(MEM_WORDS * 4);
    assign host_rdata     = ram_rdata;
    assign card_out_data  = ram_rdata;
    assign card_out_valid = !to_host && st_q.ob_valid;
    assign bad_acc        = st_q.bad;

    // R8: a read without read permission must leave the flag raised
    a_r8_bad_read: assert property (@(posedge clk) disable iff (rst)
        host_rd && !rd_avail |=> bad_acc);
    // R8: a write without write permission must leave the flag raised
    a_r8_bad_write: assert property (@(posedge clk) disable iff (rst)
        host_wr && !wr_room |=> bad_acc);
    // R9: sticky until cleared
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        bad_acc && !bad_clr |=> bad_acc);
    // R12: outgoing card word held under backpressure
    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        card_out_valid && !card_out_ready |=> card_out_valid && $stable(card_out_data));
    // R1: reset leaves no status raised
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !bad_acc && !rd_avail && !card_out_valid);
endmodule

// File: tb/sdbuf_top_bench.sv
`timescale 1ns/1ps
module sdbuf_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dir_to_host = 1'b1;
    logic [10:0] blk_len = 11'd8;
    logic [10:0] cap_blk_bytes;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        host_rd = 1'b0;
    logic [31:0] host_rdata;
    logic        rd_avail, wr_room, bad_acc;
    logic        bad_clr = 1'b0;
    logic        card_in_valid = 1'b0;
    logic [31:0] card_in_data = '0;
    logic        card_in_ready;
    logic        card_out_valid;
    logic [31:0] card_out_data;
    logic        card_out_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] host_q[$];
    logic [31:0] card_q[$];

    always #5 clk = ~clk;

    sdbuf_top u_sdbuf_top (
        .clk(clk), .rst(rst), .dir_to_host(dir_to_host), .blk_len(blk_len),
        .cap_blk_bytes(cap_blk_bytes), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata), .rd_avail(rd_avail),
        .wr_room(wr_room), .bad_acc(bad_acc), .bad_clr(bad_clr),
        .card_in_valid(card_in_valid), .card_in_data(card_in_data),
        .card_in_ready(card_in_ready), .card_out_valid(card_out_valid),
        .card_out_data(card_out_data), .card_out_ready(card_out_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_reset(input logic dir, input logic [10:0] len);
        @(posedge clk); #1;
        rst = 1'b1; dir_to_host = dir; blk_len = len;
        tick(1);
        rst = 1'b0;
    endtask

    // Monitor: scoreboard pops at the negative edge
    always @(negedge clk) begin
        if (!rst && host_rd && rd_avail) begin
            if (host_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected host word", host_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                e = host_q.pop_front();
                chk(host_rdata == e, "R5", "host read order", host_rdata, e);
            end
        end
        if (!rst && card_out_valid && card_out_ready) begin
            if (card_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected card word", card_out_data, 32'h0);
            end else begin
                logic [31:0] e;
                e = card_q.pop_front();
                chk(card_out_data == e, "R7", "card out order", card_out_data, e);
            end
        end
    end

    task automatic card_push(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            bit acc;
            acc = 1'b0;
            card_in_valid = 1'b1;
            card_in_data  = base + i;
            while (!acc) begin
                @(negedge clk);
                acc = card_in_ready;
                if (acc) host_q.push_back(card_in_data);
                @(posedge clk); #1;
            end
        end
        card_in_valid = 1'b0;
    endtask

    task automatic host_read(input int n);
        for (int i = 0; i < n; i++) begin
            while (!rd_avail) tick(1);
            host_rd = 1'b1;
            tick(1);
            host_rd = 1'b0;
        end
    endtask

    task automatic host_write(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            while (!wr_room) tick(1);
            host_wr = 1'b1;
            host_wdata = base + i;
            card_q.push_back(base + i);
            tick(1);
            host_wr = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Scenario A: dual bank, card to host, 2-word blocks
        do_reset(1'b1, 11'd8);
        chk(rd_avail == 1'b0, "R1", "rd_avail after reset", rd_avail, 0);
        chk(bad_acc == 1'b0, "R1", "bad_acc after reset", bad_acc, 0);
        chk(card_in_ready == 1'b1, "R1", "card_in_ready after reset", card_in_ready, 1);
        chk(card_out_valid == 1'b0, "R1", "card_out_valid after reset", card_out_valid, 0);
        chk(cap_blk_bytes == 11'd1024, "R11", "capability", cap_blk_bytes, 1024);
        card_push(2, 32'hA000);
        chk(rd_avail == 1'b0, "R5", "rd_avail one cycle after block", rd_avail, 0);
        tick(1);
        chk(rd_avail == 1'b1, "R5", "rd_avail two cycles after block", rd_avail, 1);
        chk(card_in_ready == 1'b1, "R3", "second bank open while draining", card_in_ready, 1);
        card_push(2, 32'hA100);
        tick(1);
        chk(card_in_ready == 1'b0, "R3", "stall with both banks full", card_in_ready, 0);
        // R10: illegal write leaves prefetch untouched
        host_wr = 1'b1; host_wdata = 32'hDEAD_BEEF;
        tick(1);
        host_wr = 1'b0;
        chk(bad_acc == 1'b1, "R8", "write in read direction", bad_acc, 1);
        chk(host_rdata == host_q[0], "R10", "prefetch unchanged by write", host_rdata, host_q[0]);
        bad_clr = 1'b1; tick(1); bad_clr = 1'b0;
        chk(bad_acc == 1'b0, "R9", "clear pulse", bad_acc, 0);
        host_read(4);
        tick(2);
        chk(rd_avail == 1'b0, "R6", "rd_avail after last word", rd_avail, 0);
        chk(host_q.size() == 0, "R5", "all host words read", host_q.size(), 0);
        host_rd = 1'b1; tick(1); host_rd = 1'b0;
        chk(bad_acc == 1'b1, "R8", "read without data", bad_acc, 1);
        tick(3);
        chk(bad_acc == 1'b1, "R9", "sticky flag", bad_acc, 1);
        host_rd = 1'b1; bad_clr = 1'b1; tick(1); host_rd = 1'b0; bad_clr = 1'b0;
        chk(bad_acc == 1'b1, "R9", "set wins over clear", bad_acc, 1);
        bad_clr = 1'b1; tick(1); bad_clr = 1'b0;
        chk(bad_acc == 1'b0, "R9", "clear after set", bad_acc, 0);

        // Scenario B: single bank, 600 bytes = 150 words
        do_reset(1'b1, 11'd600);
        card_push(150, 32'hB000);
        chk(card_in_ready == 1'b0, "R4", "single bank stalls after block", card_in_ready, 0);
        tick(1);
        chk(rd_avail == 1'b1 && card_in_ready == 1'b0, "R4", "no refill while draining",
            {31'd0, card_in_ready}, 0);
        host_read(150);
        tick(1);
        chk(card_in_ready == 1'b1, "R4", "refill after drain", card_in_ready, 1);
        chk(rd_avail == 1'b0, "R6", "empty after single block", rd_avail, 0);

        // Scenario C: dual bank, host to card, 4-word blocks
        card_out_ready = 1'b0;
        do_reset(1'b0, 11'd16);
        chk(wr_room == 1'b1, "R1", "wr_room after reset", wr_room, 1);
        host_write(4, 32'hC000);
        chk(wr_room == 1'b0, "R7", "wr_room drops after last word", wr_room, 0);
        tick(1);
        chk(wr_room == 1'b1, "R7", "wr_room back for second bank", wr_room, 1);
        host_write(4, 32'hC100);
        tick(2);
        chk(wr_room == 1'b0, "R3", "both banks occupied", wr_room, 0);
        host_wr = 1'b1; host_wdata = 32'h0BAD; tick(1); host_wr = 1'b0;
        chk(bad_acc == 1'b1, "R8", "write without room", bad_acc, 1);
        for (int i = 0; i < 40; i++) begin
            card_out_ready = i[0];
            tick(1);
        end
        card_out_ready = 1'b0;
        chk(card_q.size() == 0, "R7", "all card words delivered", card_q.size(), 0);
        chk(card_out_valid == 1'b0, "R8", "rejected word not forwarded", card_out_valid, 0);
        chk(wr_room == 1'b1, "R7", "room after drain", wr_room, 1);

        // Scenario D: length rounding and capping
        do_reset(1'b1, 11'd0);
        card_push(1, 32'hD000);
        tick(1);
        chk(rd_avail == 1'b1, "R2", "zero length is one word", rd_avail, 1);
        host_read(1);
        do_reset(1'b1, 11'd5);
        card_push(1, 32'hD100);
        tick(3);
        chk(rd_avail == 1'b0, "R2", "5 bytes need two words", rd_avail, 0);
        card_push(1, 32'hD101);
        tick(1);
        chk(rd_avail == 1'b1, "R2", "block done after two words", rd_avail, 1);
        host_read(2);
        do_reset(1'b0, 11'd2047);
        host_write(255, 32'hE000);
        chk(wr_room == 1'b1, "R2", "cap not reached at 255", wr_room, 1);
        host_write(1, 32'hE0FF);
        chk(wr_room == 1'b0, "R2", "capped at 256 words", wr_room, 0);
        tick(2);
        chk(wr_room == 1'b0, "R4", "single bank holds", wr_room, 0);
        card_out_ready = 1'b1;
        tick(270);
        card_out_ready = 1'b0;
        chk(card_q.size() == 0, "R7", "capped block delivered", card_q.size(), 0);
        chk(wr_room == 1'b1, "R4", "room after single drain", wr_room, 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule